// File: doc/BRIEF.md
# TV Audio Output Mode Selector

This block decides what the two audio line outputs of a television sound decoder carry. It looks at two synchronous detection flags, one for the stereo pilot and one for the second-program carrier. It combines them with the listener's request: a two-bit service select and a forced-mono override. From these it produces a source-select code for each output channel and a two-bit mode indicator. When the requested service is not on air, both channels fall back to the mono sum. The mute request overrides everything else.

The block also returns a registered status byte that carries the two detection flags, for readback by a control interface. Every output is registered on the system clock. A change on any input shows at the outputs after the next rising edge, so downstream audio switching and the front-panel indicator update together.

Top module: `tv_audio_mode_sel`

## Requirements
- R1: While reset is asserted, and on the first edge after it, both source selects are MUTE (000), the mode indicator is 00 and the status byte is 00h. Source codes are 000 mute, 001 left, 010 right, 011 L+R sum, 100 second program. Mode codes are 00 mono, 01 second program, 10 stereo, 11 stereo plus second program.
- R2: Outputs change only on a rising clock edge. After an input change they show the value decoded from the inputs sampled at that edge, with one cycle of latency.
- R3: Service select 11 (mute) drives both source selects to MUTE and the mode indicator to 00, whatever the detection flags and the forced-mono bit are.
- R4: With forced mono set and service select not 11, both channels carry the sum (011) and the mode indicator is 00, whatever the detection flags are.
- R5: Service select 00 (stereo) without forced mono: with the pilot detected, left is 001, right is 010 and the mode is 10. Otherwise both channels are 011 and the mode is 00.
- R6: Service select 01 (second program) without forced mono: with the carrier detected, both channels are 100 and the mode is 01. Otherwise both channels are 011 and the mode is 00.
- R7: Service select 10 (both) without forced mono: with the carrier detected, left is 011 and right is 100, and the mode is 11 if the pilot is also detected, otherwise 01. With only the pilot, left is 001, right is 010 and the mode is 10. With neither, both are 011 and the mode is 00.
- R8: The status byte has bit 7 equal to the pilot flag and bit 6 equal to the carrier flag, both sampled at the previous edge. Bits 5 to 0 are zero.
- R9: The left select never carries the right code (010), and the right select never carries the left code (001).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| pilot_seen | input | 1 | Stereo pilot detected flag |
| sap_seen | input | 1 | Second-program carrier detected flag |
| svc_sel | input | 2 | Requested service: 00 stereo, 01 second program, 10 both, 11 mute |
| mono_force | input | 1 | 1 forces the mono sum on both channels |
| left_src | output | 3 | Left channel source code |
| right_src | output | 3 | Right channel source code |
| mode_ind | output | 2 | Mode indicator |
| stat_byte | output | 8 | Registered detection status |

## Verification
Two overrides can apply in the same cycle: a mute request together with forced mono, and a select change on the same edge as a detection flag toggle. Directed cases set mute and forced mono together under every flag combination; the expected result is that mute wins. Random stimulus changes the select and the flags on the same edge. Each result is judged one cycle later against a bench reference function. A sample taken just after the inputs are driven confirms that nothing moves before the edge.

// File: rtl/tvsel_pkg.sv
package tvsel_pkg;
   localparam int SRC_W  = 3;
   localparam int SEL_W  = 2;
   localparam int MODE_W = 2;

   typedef enum logic [SRC_W-1:0] {
      SRC_MUTE  = 3'd0,
      SRC_LEFT  = 3'd1,
      SRC_RIGHT = 3'd2,
      SRC_SUM   = 3'd3,
      SRC_SAP   = 3'd4
   } src_t;

   typedef enum logic [SEL_W-1:0] {
      SEL_STEREO = 2'b00,
      SEL_SAP    = 2'b01,
      SEL_BOTH   = 2'b10,
      SEL_MUTE   = 2'b11
   } sel_t;

   typedef enum logic [MODE_W-1:0] {
      MD_MONO  = 2'b00,
      MD_SAP   = 2'b01,
      MD_ST    = 2'b10,
      MD_STSAP = 2'b11
   } mode_t;

   typedef struct packed {
      src_t  lsrc;
      src_t  rsrc;
      mode_t mode;
   } route_t;

   localparam int ROUTE_W = $bits(route_t);
endpackage

// File: rtl/tvsel_decode.sv
module tvsel_decode
   import tvsel_pkg::*;
(
   input  logic               pilot,
   input  logic               sap,
   input  logic [SEL_W-1:0]   sel,
   input  logic               mono,
   output route_t             route
);
   sel_t sel_e;
   assign sel_e = sel_t'(sel);

   always_comb begin
      route = '{lsrc: SRC_SUM, rsrc: SRC_SUM, mode: MD_MONO};
      if (sel_e == SEL_MUTE) begin
         route = '{lsrc: SRC_MUTE, rsrc: SRC_MUTE, mode: MD_MONO};
      end else if (!mono) begin
         case (sel_e)
            SEL_STEREO: begin
               if (pilot) route = '{lsrc: SRC_LEFT, rsrc: SRC_RIGHT, mode: MD_ST};
            end
            SEL_SAP: begin
               if (sap) route = '{lsrc: SRC_SAP, rsrc: SRC_SAP, mode: MD_SAP};
            end
            SEL_BOTH: begin
               if (sap)
                  route = '{lsrc: SRC_SUM, rsrc: SRC_SAP,
                            mode: (pilot ? MD_STSAP : MD_SAP)};
               else if (pilot)
                  route = '{lsrc: SRC_LEFT, rsrc: SRC_RIGHT, mode: MD_ST};
            end
            default: ;
         endcase
      end
   end
endmodule

// File: rtl/tvsel_stage.sv
module tvsel_stage #(
   parameter int             W     = 8,
   parameter logic [W-1:0]   RST_V = '0
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic [W-1:0]  d,
   output logic [W-1:0]  q
);
   generate
      if (W < 1) begin : g_bad_w
         $error("tvsel_stage: W must be at least 1");
      end
   endgenerate

   always_ff @(posedge clk) begin
      if (!rst_n) q <= RST_V;
      else        q <= d;
   end
endmodule

// File: rtl/tv_audio_mode_sel.sv
module tv_audio_mode_sel
   import tvsel_pkg::*;
#(
   parameter int STAT_W = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pilot_seen,
   input  logic              sap_seen,
   input  logic [1:0]        svc_sel,
   input  logic              mono_force,
   output logic [2:0]        left_src,
   output logic [2:0]        right_src,
   output logic [1:0]        mode_ind,
   output logic [STAT_W-1:0] stat_byte
);
   localparam route_t ROUTE_RST = '{lsrc: SRC_MUTE, rsrc: SRC_MUTE, mode: MD_MONO};

   generate
      if (STAT_W < 2) begin : g_bad_stat
         $error("tv_audio_mode_sel: STAT_W must hold both flags");
      end
   endgenerate

   route_t                 route_d;
   logic [ROUTE_W-1:0]     route_q;
   logic [STAT_W-1:0]      stat_d;

   tvsel_decode u_dec (
      .pilot (pilot_seen),
      .sap   (sap_seen),
      .sel   (svc_sel),
      .mono  (mono_force),
      .route (route_d)
   );

   tvsel_stage #(.W(ROUTE_W), .RST_V(ROUTE_RST)) u_route_q (
      .clk (clk), .rst_n (rst_n), .d (route_d), .q (route_q)
   );

   generate
      if (STAT_W > 2) begin : g_stat_pad
         assign stat_d = {pilot_seen, sap_seen, {(STAT_W-2){1'b0}}};
      end else begin : g_stat_bare
         assign stat_d = {pilot_seen, sap_seen};
      end
   endgenerate

   tvsel_stage #(.W(STAT_W), .RST_V('0)) u_stat_q (
      .clk (clk), .rst_n (rst_n), .d (stat_d), .q (stat_byte)
   );

   route_t route_o;
   assign route_o   = route_t'(route_q);
   assign left_src  = route_o.lsrc;
   assign right_src = route_o.rsrc;
   assign mode_ind  = route_o.mode;
endmodule

// File: rtl/tvsel_chk.sv
module tvsel_chk #(
   parameter int STAT_W = 8
) (
   input logic              clk,
   input logic              rst_n,
   input logic              pilot_seen,
   input logic              sap_seen,
   input logic [1:0]        svc_sel,
   input logic              mono_force,
   input logic [2:0]        left_src,
   input logic [2:0]        right_src,
   input logic [1:0]        mode_ind,
   input logic [STAT_W-1:0] stat_byte
);
   p_mute_wins_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (svc_sel == 2'b11) |=> (left_src == 3'd0 && right_src == 3'd0 && mode_ind == 2'b00));

   p_force_sum_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (mono_force && svc_sel != 2'b11) |=> (left_src == 3'd3 && right_src == 3'd3 && mode_ind == 2'b00));

   p_pilot_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (stat_byte[STAT_W-1] == $past(pilot_seen) && stat_byte[STAT_W-2] == $past(sap_seen)));

   p_no_swap_r9: assert property (@(posedge clk) disable iff (!rst_n)
      (left_src != 3'd2 && right_src != 3'd1));

   p_sap_mode_carries_r7: assert property (@(posedge clk) disable iff (!rst_n)
      mode_ind[0] |-> (left_src == 3'd4 || right_src == 3'd4));

   p_stereo_needs_pilot_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (left_src == 3'd1) |-> $past(pilot_seen));
endmodule

bind tv_audio_mode_sel tvsel_chk #(.STAT_W(STAT_W)) u_chk (.*);

// File: tb/tv_audio_mode_sel_bench.sv
module tv_audio_mode_sel_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pilot_seen = 1'b0, sap_seen = 1'b0, mono_force = 1'b0;
   logic [1:0] svc_sel = 2'b00;
   logic [2:0] left_src, right_src;
   logic [1:0] mode_ind;
   logic [7:0] stat_byte;

   int total = 0, bad = 0;
   bit done = 1'b0;

   always #2 clk = ~clk;

   tv_audio_mode_sel u_tv_audio_mode_sel (
      .clk(clk), .rst_n(rst_n), .pilot_seen(pilot_seen), .sap_seen(sap_seen),
      .svc_sel(svc_sel), .mono_force(mono_force), .left_src(left_src),
      .right_src(right_src), .mode_ind(mode_ind), .stat_byte(stat_byte)
   );

   // Reference per R3..R7: returns {left, right, mode}
   function automatic logic [7:0] ref_route(input logic p, input logic s,
                                            input logic [1:0] sel, input logic m);
      logic [7:0] r;
      r = {3'd3, 3'd3, 2'b00};
      if (sel == 2'b11) r = {3'd0, 3'd0, 2'b00};
      else if (!m) begin
         case (sel)
            2'b00: if (p) r = {3'd1, 3'd2, 2'b10};
            2'b01: if (s) r = {3'd4, 3'd4, 2'b01};
            2'b10: if (s) r = {3'd3, 3'd4, (p ? 2'b11 : 2'b01)};
                   else if (p) r = {3'd1, 3'd2, 2'b10};
            default: ;
         endcase
      end
      return r;
   endfunction

   task automatic check(input string req, input logic [15:0] act, input logic [15:0] exp);
      total++;
      if (act !== exp) begin
         bad++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   task automatic apply_and_check(input string req, input logic p, input logic s,
                                  input logic [1:0] sel, input logic m);
      logic [7:0] prev;
      @(negedge clk);
      prev = {left_src, right_src, mode_ind};
      pilot_seen = p; sap_seen = s; svc_sel = sel; mono_force = m;
      #1;
      check("R2 hold before edge", {8'h0, left_src, right_src, mode_ind}, {8'h0, prev});
      @(negedge clk);
      check(req, {8'h0, left_src, right_src, mode_ind}, {8'h0, ref_route(p, s, sel, m)});
      check("R8 status", {8'h0, stat_byte}, {8'h0, p, s, 6'b0});
      check("R9 no swap", {15'h0, (left_src == 3'd2 || right_src == 3'd1)}, 16'h0);
   endtask

   initial begin
      #400000;
      if (!done) begin
         bad++; total++;
         $display("FAIL watchdog actual=hung expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'd7321));
      // R1: reset state, with inputs active during reset
      pilot_seen = 1'b1; sap_seen = 1'b1; svc_sel = 2'b10;
      repeat (3) @(posedge clk);
      @(negedge clk);
      check("R1 reset outputs", {8'h0, left_src, right_src, mode_ind}, 16'h0);
      check("R1 reset status", {8'h0, stat_byte}, 16'h0);
      rst_n = 1'b1;
      // directed: every flag combination with mute and forced mono together (R3)
      for (int k = 0; k < 4; k++) begin
         apply_and_check("R3 mute with forced mono", k[1], k[0], 2'b11, 1'b1);
         apply_and_check("R3 mute", k[1], k[0], 2'b11, 1'b0);
         apply_and_check("R4 forced mono", k[1], k[0], 2'b00, 1'b1);
         apply_and_check("R4 forced mono both", k[1], k[0], 2'b10, 1'b1);
         apply_and_check("R5 stereo select", k[1], k[0], 2'b00, 1'b0);
         apply_and_check("R6 sap select", k[1], k[0], 2'b01, 1'b0);
         apply_and_check("R7 both select", k[1], k[0], 2'b10, 1'b0);
      end
      // random: select and flags changing on the same edge (R2..R8)
      for (int i = 0; i < 400; i++) begin
         logic [4:0] v;
         v = 5'($urandom());
         apply_and_check("R2 random route", v[0], v[1], v[3:2], (v[4] & (($urandom() % 4) == 0)));
      end
      // R1: reset again mid-run
      @(negedge clk);
      rst_n = 1'b0;
      @(negedge clk);
      check("R1 re-reset outputs", {8'h0, left_src, right_src, mode_ind}, 16'h0);
      check("R1 re-reset status", {8'h0, stat_byte}, 16'h0);
      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end
endmodule